// File: doc/BRIEF.md
# Multi-Core Mailbox Doorbell Unit

This block holds sixteen 32-bit mailbox registers used by four processor cores to ring one another. Every core owns four mailboxes. Software never needs a read-modify-write to update one. Each mailbox has two word addresses. A write to the first address merges the written ones into the mailbox. A write to the second address removes the bits written as one.

Each mailbox drives one output line. The line stays high for as long as any bit of that mailbox is set, so a receiving core sees a level request until it has cleared every bit. A separate interrupt router takes these sixteen lines and delivers them to the cores. That router, and any bus bridging, sit outside this block.

The register port is a plain memory-mapped port: byte address, write enable, write data, and read data. Read data is combinational on the address.

Top module: `mbox_doorbell`

## Requirements
- R1: Reset (rst_n low at a rising edge) clears all sixteen mailboxes. After reset every bit of mbox_active is 0 and every mapped address reads 0.
- R2: Addresses are byte offsets.
    - Offsets 0x80 to 0xBF form the set window, and offsets 0xC0 to 0xFF form the clear window.
    - Inside a window, the mailbox index is offset bits [5:2], equal to core*4 + box. For example, core 0 box 3 is at 0x8C for set and 0xCC for clear.
    - mbox_active bit i belongs to mailbox index i.
- R3: A write to a set address ORs reg_wdata into that mailbox. Bits already set stay set.
- R4: A write to a clear address clears each mailbox bit whose reg_wdata bit is 1. Bits written as 0 keep their value.
- R5: mbox_active[i] is 1 exactly when mailbox i is nonzero. It reflects a write from just after the rising edge that takes the write.
- R6: Reading either the set address or the clear address of a mailbox returns its current contents, in the same cycle as the address.
- R7: These accesses are unmapped: an offset below 0x80, or an offset whose bits [1:0] are not 00. An unmapped read returns 0, and an unmapped write changes no mailbox.
- R8: A write changes only the mailbox it addresses.
- R9: While reg_wr_en is 0, no mailbox changes, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wr_en | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data: ones to set or ones to clear |
| reg_rdata | output | 32 | Contents of the addressed mailbox, 0 when unmapped |
| mbox_active | output | 16 | Level request per mailbox, high while nonzero |

## Verification
A write takes effect at the rising edge where reg_wr_en is sampled high. From just after that edge, both mbox_active and the read data of the same address already show the new contents, with no further cycle of delay. Read data follows reg_addr combinationally within the cycle.

The bench drives address, data and strobe at the falling edge. It drops the strobe at the next falling edge and samples read data and mbox_active there, one full edge after the write was taken. The bound properties check the same one-cycle relation with |=> from the write cycle.

// File: rtl/mbox_pkg.sv
// Package: shared types for the mailbox doorbell unit.
// Assumes: word-addressed registers of four bytes.
package mbox_pkg;

    // Which address window an access falls into.
    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_SET  = 2'd1,
        WIN_CLR  = 2'd2
    } win_e;

    // Byte offset bits below the word index.
    localparam int WORD_LSB = 2;

endpackage

// File: rtl/mbox_addr_decode.sv
// Module: mbox_addr_decode
// Splits a byte offset into a window kind and a mailbox index.
// Assumes: both window bases are aligned to the window size. Any access
// that is not word aligned counts as unmapped.
module mbox_addr_decode
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NUM_BOX = 16,
    parameter logic [ADDR_W-1:0] SET_BASE = 8'h80,
    parameter logic [ADDR_W-1:0] CLR_BASE = 8'hC0
) (
    input  logic [ADDR_W-1:0]          addr,
    output win_e                       win,
    output logic [$clog2(NUM_BOX)-1:0] idx
);
    localparam int IDX_W = $clog2(NUM_BOX);
    localparam int TAG_LSB = IDX_W + WORD_LSB;

    logic aligned;
    logic set_tag_hit;
    logic clr_tag_hit;

    // Purpose: compare the high offset bits against each window base.
    always_comb begin
        aligned     = (addr[WORD_LSB-1:0] == '0);
        set_tag_hit = (addr[ADDR_W-1:TAG_LSB] == SET_BASE[ADDR_W-1:TAG_LSB]);
        clr_tag_hit = (addr[ADDR_W-1:TAG_LSB] == CLR_BASE[ADDR_W-1:TAG_LSB]);
        if (aligned && set_tag_hit)      win = WIN_SET;
        else if (aligned && clr_tag_hit) win = WIN_CLR;
        else                             win = WIN_NONE;
        idx = addr[TAG_LSB-1:WORD_LSB];
    end

endmodule

// File: rtl/mbox_cell.sv
// Module: mbox_cell
// One mailbox register with set and clear masks and a level request output.
// Assumes: both masks may be nonzero together. The clear is applied first,
// then the set, so a bit in both masks ends up set.
module mbox_cell #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_mask,
    input  logic [DATA_W-1:0] clr_mask,
    output logic [DATA_W-1:0] value_q,
    output logic              active
);

    // Purpose: hold the mailbox bits; clear first, then merge the set bits.
    always_ff @(posedge clk) begin
        if (!rst_n) value_q <= '0;
        else        value_q <= (value_q & ~clr_mask) | set_mask;
    end

    // Purpose: raise the level request while any bit is set.
    always_comb active = |value_q;

endmodule

// File: rtl/mbox_read_mux.sv
// Module: mbox_read_mux
// Returns the contents of the addressed mailbox, or zero when unmapped.
// Assumes: the set and clear windows both alias the same storage.
module mbox_read_mux
    import mbox_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_BOX = 16
) (
    input  logic [NUM_BOX-1:0][DATA_W-1:0] values,
    input  win_e                           win,
    input  logic [$clog2(NUM_BOX)-1:0]     idx,
    output logic [DATA_W-1:0]              rdata
);

    // Purpose: pick one mailbox and force zero outside both windows.
    always_comb begin
        if (win == WIN_NONE) rdata = '0;
        else                 rdata = values[idx];
    end

endmodule

// File: rtl/mbox_doorbell.sv
// Module: mbox_doorbell (top)
// Sixteen mailboxes, each with a write-ones-to-set address and a
// write-ones-to-clear address, plus a level request per mailbox.
// Assumes: single register port, reads are combinational on the address,
// writes take effect at the rising edge with reg_wr_en high.
module mbox_doorbell
    import mbox_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int BOXES_PER_CORE = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] SET_BASE = 8'h80,
    parameter logic [ADDR_W-1:0] CLR_BASE = 8'hC0
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [ADDR_W-1:0]                   reg_addr,
    input  logic                                reg_wr_en,
    input  logic [DATA_W-1:0]                   reg_wdata,
    output logic [DATA_W-1:0]                   reg_rdata,
    output logic [NUM_CORES*BOXES_PER_CORE-1:0] mbox_active
);
    localparam int NUM_BOX = NUM_CORES * BOXES_PER_CORE;
    localparam int IDX_W = $clog2(NUM_BOX);

    win_e                           acc_win;
    logic [IDX_W-1:0]               acc_idx;
    logic [NUM_BOX-1:0][DATA_W-1:0] box_q;
    logic [NUM_BOX-1:0][DATA_W-1:0] set_mask;
    logic [NUM_BOX-1:0][DATA_W-1:0] clr_mask;

    mbox_addr_decode #(
        .ADDR_W  (ADDR_W),
        .NUM_BOX (NUM_BOX),
        .SET_BASE(SET_BASE),
        .CLR_BASE(CLR_BASE)
    ) u_decode (
        .addr(reg_addr),
        .win (acc_win),
        .idx (acc_idx)
    );

    for (genvar b = 0; b < NUM_BOX; b++) begin : g_box
        logic sel;

        // Purpose: steer the write data into this mailbox's set or clear mask.
        always_comb begin
            sel         = reg_wr_en && (acc_idx == IDX_W'(b));
            set_mask[b] = (sel && acc_win == WIN_SET) ? reg_wdata : '0;
            clr_mask[b] = (sel && acc_win == WIN_CLR) ? reg_wdata : '0;
        end

        mbox_cell #(
            .DATA_W(DATA_W)
        ) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_mask(set_mask[b]),
            .clr_mask(clr_mask[b]),
            .value_q (box_q[b]),
            .active  (mbox_active[b])
        );
    end

    mbox_read_mux #(
        .DATA_W (DATA_W),
        .NUM_BOX(NUM_BOX)
    ) u_rmux (
        .values(box_q),
        .win   (acc_win),
        .idx   (acc_idx),
        .rdata (reg_rdata)
    );

endmodule

// File: rtl/mbox_doorbell_chk.sv
// Module: mbox_doorbell_chk
// Port-level properties of the mailbox doorbell unit, bound to the top.
// Assumes: the default window layout of the top (aligned bases).
module mbox_doorbell_chk #(
    parameter int NUM_CORES = 4,
    parameter int BOXES_PER_CORE = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] SET_BASE = 8'h80,
    parameter logic [ADDR_W-1:0] CLR_BASE = 8'hC0
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic [ADDR_W-1:0]                   reg_addr,
    input logic                                reg_wr_en,
    input logic [DATA_W-1:0]                   reg_wdata,
    input logic [DATA_W-1:0]                   reg_rdata,
    input logic [NUM_CORES*BOXES_PER_CORE-1:0] mbox_active
);
    localparam int NUM_BOX = NUM_CORES * BOXES_PER_CORE;
    localparam int IDX_W = $clog2(NUM_BOX);
    localparam int HI = IDX_W + 2;

    logic             is_set;
    logic             is_clr;
    logic             mapped;
    logic [IDX_W-1:0] cidx;

    // Purpose: classify the current access from the port alone.
    always_comb begin
        is_set = (reg_addr[1:0] == 2'b00) && (reg_addr[ADDR_W-1:HI] == SET_BASE[ADDR_W-1:HI]);
        is_clr = (reg_addr[1:0] == 2'b00) && (reg_addr[ADDR_W-1:HI] == CLR_BASE[ADDR_W-1:HI]);
        mapped = is_set || is_clr;
        cidx   = reg_addr[HI-1:2];
    end

    // R1: the first cycle out of reset shows no request.
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mbox_active == '0));

    // R3: setting any one raises the addressed request.
    a_r3_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && is_set && reg_wdata != '0) |=> mbox_active[$past(cidx)]);

    // R4: clearing with all ones drops the addressed request.
    a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && is_clr && (&reg_wdata)) |=> !mbox_active[$past(cidx)]);

    // R5: read data is nonzero exactly when the request is up.
    a_r5_level_matches: assert property (@(posedge clk) disable iff (!rst_n)
        mapped |-> ((reg_rdata != '0) == mbox_active[cidx]));

    // R7: unmapped reads return zero.
    a_r7_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (reg_rdata == '0));

    // R7: unmapped writes leave every request unchanged.
    a_r7_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !mapped) |=> $stable(mbox_active));

    // R8: a mapped write disturbs no other mailbox's request.
    a_r8_others_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && mapped) |=>
        (((mbox_active ^ $past(mbox_active)) & ~(NUM_BOX'(1) << $past(cidx))) == '0));

    // R9: with no write strobe nothing changes.
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr_en |=> $stable(mbox_active));

endmodule

bind mbox_doorbell mbox_doorbell_chk #(
    .NUM_CORES     (NUM_CORES),
    .BOXES_PER_CORE(BOXES_PER_CORE),
    .DATA_W        (DATA_W),
    .ADDR_W        (ADDR_W),
    .SET_BASE      (SET_BASE),
    .CLR_BASE      (CLR_BASE)
) chk_i (.*);

// File: tb/mbox_doorbell_tb_top.sv
`timescale 1ns/1ps
// Bench for mbox_doorbell: a vector table walked by one loop, then directed
// tests for readback aliases, idle hold, index mapping and reset.
module mbox_doorbell_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [15:0] mbox_active;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mbox_doorbell dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_wr_en  (reg_wr_en),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .mbox_active(mbox_active)
    );

    // Entry: {addr[8], wdata[32], expected read of addr after write[32], expected active[16]}
    localparam int NVEC = 12;
    localparam logic [87:0] VEC [NVEC] = '{
        {8'h80, 32'h0000_00F1, 32'h0000_00F1, 16'h0001}, // R3 first set
        {8'h80, 32'h0000_0F00, 32'h0000_0FF1, 16'h0001}, // R3 merge keeps old bits
        {8'h8C, 32'h8000_0000, 32'h8000_0000, 16'h0009}, // R2 core0 box3 at 0x8C
        {8'hBC, 32'h0000_0001, 32'h0000_0001, 16'h8009}, // R2 last index 15
        {8'hC0, 32'h0000_0F01, 32'h0000_00F0, 16'h8009}, // R4 partial clear
        {8'hC0, 32'h0000_00F0, 32'h0000_0000, 16'h8008}, // R5 request drops at zero
        {8'h44, 32'hFFFF_FFFF, 32'h0000_0000, 16'h8008}, // R7 low offset ignored
        {8'h90, 32'h00AA_0000, 32'h00AA_0000, 16'h8018}, // R8 core1 box0 index 4
        {8'hCC, 32'h0000_0000, 32'h8000_0000, 16'h8018}, // R4 zero mask keeps bits
        {8'hFC, 32'hFFFF_FFFF, 32'h0000_0000, 16'h0018}, // R4 full clear of index 15
        {8'h93, 32'h0000_0001, 32'h0000_0000, 16'h0018}, // R7 misaligned ignored
        {8'hD0, 32'hFFFF_FFFF, 32'h0000_0000, 16'h0008}  // R4 clear index 4
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Write at a falling edge, drop the strobe at the next falling edge.
    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic read_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        chk("R1 active in reset", {16'h0, mbox_active}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 active after reset", {16'h0, mbox_active}, 32'h0);
        read_chk("R1 read 0x80", 8'h80, 32'h0);
        read_chk("R1 read 0xFC", 8'hFC, 32'h0);

        // Table walk: write, then check read of the same address and all requests.
        for (int i = 0; i < NVEC; i++) begin
            do_write(VEC[i][87:80], VEC[i][79:48]);
            #1;
            chk($sformatf("R3/R4 vec %0d read", i), reg_rdata, VEC[i][47:16]);
            chk($sformatf("R5 vec %0d active", i), {16'h0, mbox_active}, {16'h0, VEC[i][15:0]});
        end

        // R6: both addresses of a mailbox read the same contents.
        read_chk("R6 set alias 0x8C", 8'h8C, 32'h8000_0000);
        read_chk("R6 clear alias 0xCC", 8'hCC, 32'h8000_0000);
        read_chk("R6 empty 0x88", 8'h88, 32'h0);
        read_chk("R7 read 0x00", 8'h00, 32'h0);

        // R9: no strobe, changing data and address change nothing.
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            reg_addr  = (k % 2 == 0) ? 8'h8C : 8'hCC;
            reg_wdata = 32'hFFFF_FFFF;
        end
        @(negedge clk);
        chk("R9 active held", {16'h0, mbox_active}, 32'h0000_0008);
        read_chk("R9 contents held", 8'h8C, 32'h8000_0000);

        // R2: core 3 box 1 is index 13 at 0xB4.
        do_write(8'hB4, 32'h0000_0010);
        #1;
        chk("R2 index 13 active", {16'h0, mbox_active}, 32'h0000_2008);
        read_chk("R2 index 13 via clear 0xF4", 8'hF4, 32'h0000_0010);
        read_chk("R8 index 3 untouched", 8'h8C, 32'h8000_0000);

        // R1: reset in mid-run clears everything.
        do_write(8'hA0, 32'h0000_0005);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 mid-run reset active", {16'h0, mbox_active}, 32'h0);
        read_chk("R1 mid-run reset 0xA0", 8'hA0, 32'h0);
        read_chk("R1 mid-run reset 0x8C", 8'h8C, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule